// File: doc/BRIEF.md
# Translation Cache With Walker Refill

This block keeps a small, fully associative set of recent virtual-to-physical page translations for 4 KB pages. A page table walker sits behind it. Each request carries a 48-bit virtual address, an access kind (read or write) and a privilege level (user or kernel). The virtual page number, bits 47:12, is compared against every valid entry at once. On a hit, the physical address and a permission verdict come back in the same cycle.

On a miss the block stops taking requests and asks the walker for the page. The walker returns a 64-bit table entry or a fault. A good entry is written into the cache and the waiting request is answered in the same cycle. A walker fault is passed straight to the requester and nothing is stored. A flush input empties the cache in one cycle. It is meant to be pulsed whenever the root table base changes on a process switch.

Top module: `xlat_cache`

## Requirements
- R1: After reset `req_ready` is 1, `walk_req_valid` and `rsp_valid` are 0, and the cache holds no entry, so the first lookup of any page misses.
- R2: A lookup accepted while idle (`req_valid` and `req_ready`) that matches a valid entry answers in the same cycle with `rsp_valid`=1 and `rsp_paddr` = {cached frame, `req_vaddr[11:0]`}.
- R3: A lookup that misses gives no response in its own cycle. From the next cycle `walk_req_valid` is 1 and `walk_req_vpn` equals the request's bits 47:12, and both hold steady until `walk_done`.
- R4: In the cycle `walk_done`=1 with `walk_fault`=0, the block answers with `rsp_paddr` = {`walk_pte[51:12]`, the pending request's bits 11:0}. It also stores the translation, so a later lookup of that page hits.
- R5: In the cycle `walk_done`=1 with `walk_fault`=1, the block answers with `rsp_fault`=3 and stores nothing, so the page still misses afterwards.
- R6: Permission codes on `rsp_fault` are 0 = allowed, 1 = write to a read-only page, and 2 = user access to a kernel-only page. The flags come from `walk_pte` bit 1 (1 = writable) and bit 2 (1 = user accessible). Code 2 wins when both problems apply. The same check applies to hit answers and to refill answers, and a refill stores the entry even when the access is refused.
- R7: A cycle with `flush`=1 invalidates every entry. A lookup in that same cycle is handled as a miss and goes to the walker.
- R8: A refill goes to the lowest-numbered empty slot. When every slot is full, a rotating pointer picks the victim. The pointer starts at slot 0, moves on by one after each such eviction, and is set back to slot 0 by reset and by `flush`.
- R9: Only one miss is outstanding at a time. While it is pending `req_ready` is 0 and requests get no answer. The answer uses the offset and access kind latched at the miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries this cycle |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle and able to take a lookup |
| req_vaddr | input | 48 | Virtual address of the lookup |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user access, 0 = kernel |
| rsp_valid | output | 1 | Answer present this cycle |
| rsp_paddr | output | 52 | Physical address, meaningful when `rsp_fault`=0 |
| rsp_fault | output | 2 | 0 ok, 1 read-only, 2 privilege, 3 walk fault |
| walk_req_valid | output | 1 | Walk requested for `walk_req_vpn` |
| walk_req_vpn | output | 36 | Virtual page number to walk |
| walk_done | input | 1 | Walker result present |
| walk_fault | input | 1 | Walker found no valid mapping |
| walk_pte | input | 64 | Final table entry: frame in 51:12, flags in 2:1 |

## Verification
The assertions rely on the walker raising `walk_done` only while `walk_req_valid` is high, for exactly one cycle, and on the requester taking a hit's answer in the cycle the request is accepted. The stimulus keeps to these rules. The walker model answers only after it has seen the request, and it drops `walk_done` at the next falling edge. The bench also keeps pressing a different address during a pending walk, which checks that the latched request alone decides the answer.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_RDONLY = 2'd1,
    FLT_PRIV   = 2'd2,
    FLT_WALK   = 2'd3
  } flt_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;

  localparam int unsigned FLAG_RW_BIT = 1;
  localparam int unsigned FLAG_US_BIT = 2;

  // privilege violation takes precedence over write protection
  function automatic flt_e perm_chk(input logic wr, input logic usr,
                                    input logic pg_rw, input logic pg_us);
    if (usr && !pg_us) return FLT_PRIV;
    if (wr && !pg_rw)  return FLT_RDONLY;
    return FLT_NONE;
  endfunction

endpackage

// File: rtl/xlat_entry_array.sv
module xlat_entry_array #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 36,
  parameter int unsigned PFN_W   = 40,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PFN_W-1:0]   lk_pfn,
  output logic               lk_rw,
  output logic               lk_us,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic               wr_rw,
  input  logic               wr_us,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [ENTRIES-1:0]             vld_q, vld_d;
  logic [ENTRIES-1:0]             match;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_sel;
  logic [ENTRIES-1:0]             rw_sel, us_sel;

  // valid bits: flush beats install
  always_comb begin
    vld_d = vld_q;
    if (flush) begin
      vld_d = '0;
    end else if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic [VPN_W-1:0] tag_q;
      logic [PFN_W-1:0] pfn_q;
      logic             rw_q, us_q;
      logic             ld_en;

      assign ld_en = wr_en && !flush && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
        if (ld_en) begin
          tag_q <= wr_vpn;
          pfn_q <= wr_pfn;
          rw_q  <= wr_rw;
          us_q  <= wr_us;
        end
      end

      assign match[g]   = vld_q[g] && (tag_q == lk_vpn);
      assign pfn_sel[g] = match[g] ? pfn_q : '0;
      assign rw_sel[g]  = match[g] & rw_q;
      assign us_sel[g]  = match[g] & us_q;
    end
  endgenerate

  // one-hot match, so an OR over the masked entries selects the hit
  always_comb begin
    lk_pfn = '0;
    lk_rw  = 1'b0;
    lk_us  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_pfn = lk_pfn | pfn_sel[i];
      lk_rw  = lk_rw | rw_sel[i];
      lk_us  = lk_us | us_sel[i];
    end
  end

  assign lk_hit    = |match;
  assign valid_vec = vld_q;

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic             all_vld;

  assign all_vld = &valid_vec;

  // lowest empty slot wins; the rotating pointer only when full
  always_comb begin
    victim_idx = rr_q;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) victim_idx = IDX_W'(i);
    end
  end

  always_comb begin
    rr_d = rr_q;
    if (flush) begin
      rr_d = '0;
    end else if (take && all_vld) begin
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic            req_user,
  input  logic            lk_ok,
  input  logic            walk_done,
  output logic            req_ready,
  output logic            pend,
  output logic [VA_W-1:0] pend_vaddr,
  output logic            pend_write,
  output logic            pend_user
);

  st_e  st_q, st_d;
  logic miss_go;

  assign req_ready = (st_q == ST_IDLE);
  assign pend      = (st_q == ST_WAIT);
  assign miss_go   = req_valid && req_ready && !lk_ok;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (miss_go)   st_d = ST_WAIT;
      ST_WAIT: if (walk_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (miss_go) begin
      pend_vaddr <= req_vaddr;
      pend_write <= req_write;
      pend_user  <= req_user;
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VA_W    = 48,
  parameter int unsigned PA_W    = 52,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PTE_W   = 64,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PFN_W  = PA_W - OFF_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             walk_req_valid,
  output logic [VPN_W-1:0] walk_req_vpn,
  input  logic             walk_done,
  input  logic             walk_fault,
  input  logic [PTE_W-1:0] walk_pte
);

  logic               lk_hit, lk_rw, lk_us, lk_ok;
  logic [PFN_W-1:0]   lk_pfn;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim_idx;
  logic               pend, pend_write, pend_user;
  logic [VA_W-1:0]    pend_vaddr;
  logic               refill, wr_en;
  flt_e               flt_c;
  logic               unused_pte_bits;

  assign lk_ok  = lk_hit && !flush;
  assign refill = pend && walk_done;
  assign wr_en  = refill && !walk_fault;

  assign unused_pte_bits = ^{walk_pte[PTE_W-1:PA_W], walk_pte[OFF_W-1:3], walk_pte[0]};

  xlat_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) arr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_vpn    (req_vaddr[VA_W-1:OFF_W]),
    .lk_hit    (lk_hit),
    .lk_pfn    (lk_pfn),
    .lk_rw     (lk_rw),
    .lk_us     (lk_us),
    .wr_en     (wr_en),
    .wr_idx    (victim_idx),
    .wr_vpn    (pend_vaddr[VA_W-1:OFF_W]),
    .wr_pfn    (walk_pte[PA_W-1:OFF_W]),
    .wr_rw     (walk_pte[FLAG_RW_BIT]),
    .wr_us     (walk_pte[FLAG_US_BIT]),
    .valid_vec (valid_vec)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) vic_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .valid_vec  (valid_vec),
    .take       (wr_en),
    .victim_idx (victim_idx)
  );

  xlat_ctrl #(.VA_W(VA_W)) ctl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_write  (req_write),
    .req_user   (req_user),
    .lk_ok      (lk_ok),
    .walk_done  (walk_done),
    .req_ready  (req_ready),
    .pend       (pend),
    .pend_vaddr (pend_vaddr),
    .pend_write (pend_write),
    .pend_user  (pend_user)
  );

  // answer: refill result first, otherwise a same-cycle hit
  always_comb begin
    rsp_valid = 1'b0;
    rsp_paddr = '0;
    flt_c     = FLT_NONE;
    if (refill) begin
      rsp_valid = 1'b1;
      if (walk_fault) begin
        flt_c = FLT_WALK;
      end else begin
        flt_c     = perm_chk(pend_write, pend_user,
                             walk_pte[FLAG_RW_BIT], walk_pte[FLAG_US_BIT]);
        rsp_paddr = {walk_pte[PA_W-1:OFF_W], pend_vaddr[OFF_W-1:0]};
      end
    end else if (req_valid && req_ready && lk_ok) begin
      rsp_valid = 1'b1;
      flt_c     = perm_chk(req_write, req_user, lk_rw, lk_us);
      rsp_paddr = {lk_pfn, req_vaddr[OFF_W-1:0]};
    end
  end

  assign rsp_fault      = flt_c;
  assign walk_req_valid = pend;
  assign walk_req_vpn   = pend_vaddr[VA_W-1:OFF_W];

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned VA_W  = 48,
  parameter int unsigned OFF_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [VA_W-1:0]       req_vaddr,
  input logic                  rsp_valid,
  input logic [1:0]            rsp_fault,
  input logic                  walk_req_valid,
  input logic [VA_W-OFF_W-1:0] walk_req_vpn,
  input logic                  walk_done,
  input logic                  walk_fault
);

  // R3
  miss_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !rsp_valid) |=>
      (walk_req_valid && walk_req_vpn == $past(req_vaddr[VA_W-1:OFF_W])));

  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_done) |=> (walk_req_valid && $stable(walk_req_vpn)));

  // R4
  refill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && walk_done) |-> rsp_valid);

  // R5
  walk_flt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && walk_done && walk_fault) |-> (rsp_fault == 2'd3));

  // R2
  rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((req_valid && req_ready) || (walk_req_valid && walk_done)));

  // R7
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && req_valid && req_ready) |-> !rsp_valid);

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !walk_done) |-> !rsp_valid);

endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .flush          (flush),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_vaddr      (req_vaddr),
  .rsp_valid      (rsp_valid),
  .rsp_fault      (rsp_fault),
  .walk_req_valid (walk_req_valid),
  .walk_req_vpn   (walk_req_vpn),
  .walk_done      (walk_done),
  .walk_fault     (walk_fault)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;

  logic        clk, rst_n, flush;
  logic        req_valid, req_ready, req_write, req_user;
  logic [47:0] req_vaddr;
  logic        rsp_valid;
  logic [51:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        walk_req_valid, walk_done, walk_fault;
  logic [35:0] walk_req_vpn;
  logic [63:0] walk_pte;

  int n_chk = 0;
  int n_err = 0;
  bit fin   = 0;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
    .walk_done(walk_done), .walk_fault(walk_fault), .walk_pte(walk_pte)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [47:0] va;
    logic        wr;
    logic        usr;
    logic [39:0] pfn;
    logic        prw;
    logic        pus;
    logic        wflt;
    logic        hit;
    logic [1:0]  code;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{48'h0000_1234_5678, 1'b0, 1'b1, 40'h00_000A_BCDE, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{48'h0000_1234_5688, 1'b1, 1'b1, 40'h00_000A_BCDE, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0},
    '{48'h7FFF_0000_0ABC, 1'b0, 1'b0, 40'h00_0001_1111, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    '{48'h7FFF_0000_0ABC, 1'b1, 1'b0, 40'h00_0001_1111, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1},
    '{48'h7FFF_0000_0ABC, 1'b0, 1'b1, 40'h00_0001_1111, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
    '{48'h7FFF_0000_0ABC, 1'b1, 1'b1, 40'h00_0001_1111, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
    '{48'h0000_4000_0000, 1'b1, 1'b1, 40'h00_0002_2222, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3},
    '{48'h0000_4000_0000, 1'b0, 1'b1, 40'h00_0002_2222, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{48'h0000_0000_5FFF, 1'b1, 1'b1, 40'h00_0003_3333, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    '{48'h0000_0000_5FFF, 1'b0, 1'b1, 40'h00_0003_3333, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0},
    '{48'h0000_1234_5678, 1'b0, 1'b0, 40'h00_000A_BCDE, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0}
  };

  function automatic logic [63:0] mk_pte(input logic [39:0] pfn, input logic rw, input logic us);
    return {12'h000, pfn, 9'h000, us, rw, 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request; a miss is served by the walker model after dly idle cycles
  task automatic access(input logic [47:0] va, input logic wr, input logic usr,
                        input logic [63:0] pte, input logic wflt, input int dly,
                        output logic hit, output logic [1:0] code, output logic [51:0] pa);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    #2;
    if (rsp_valid) begin
      hit = 1'b1; code = rsp_fault; pa = rsp_paddr;
      @(negedge clk);
      req_valid = 1'b0;
    end else begin
      hit = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(walk_req_valid && walk_req_vpn == va[47:12], "R3 walk request",
          {27'd0, walk_req_valid, walk_req_vpn}, {27'd0, 1'b1, va[47:12]});
      repeat (dly) @(negedge clk);
      walk_done = 1'b1; walk_fault = wflt; walk_pte = pte;
      #2;
      chk(rsp_valid == 1'b1, "R4 answer on walk completion", 64'(rsp_valid), 64'd1);
      code = rsp_fault; pa = rsp_paddr;
      @(negedge clk);
      walk_done = 1'b0; walk_fault = 1'b0;
    end
  endtask

  function automatic logic [47:0] pva(input int k);
    return 48'(36'h100 + 36'(k)) << 12;
  endfunction

  initial begin
    #2_000_000;
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic       h;
    logic [1:0] c;
    logic [51:0] pa;
    logic [35:0] vpn_hold;

    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    req_write = 1'b0; req_user = 1'b0; walk_done = 1'b0; walk_fault = 1'b0; walk_pte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk(req_ready == 1'b1 && walk_req_valid == 1'b0 && rsp_valid == 1'b0, "R1 reset outputs",
        {61'd0, req_ready, walk_req_valid, rsp_valid}, 64'h4);

    // vector table: R1 first miss, R2 hits, R4 refills, R5 walk fault, R6 permissions
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].va, VECS[i].wr, VECS[i].usr, mk_pte(VECS[i].pfn, VECS[i].prw, VECS[i].pus),
             VECS[i].wflt, i % 3, h, c, pa);
      chk(h == VECS[i].hit, $sformatf("R2/R4/R5 hit-or-miss vec %0d", i), 64'(h), 64'(VECS[i].hit));
      chk(c == VECS[i].code, $sformatf("R6/R5 fault code vec %0d", i), 64'(c), 64'(VECS[i].code));
      if (VECS[i].code == 2'd0)
        chk(pa == {VECS[i].pfn, VECS[i].va[11:0]}, $sformatf("R2/R4 paddr vec %0d", i),
            64'(pa), 64'({VECS[i].pfn, VECS[i].va[11:0]}));
    end

    // R7: lookup of a cached page in the flush cycle is a miss
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_vaddr = 48'h0000_1234_5678; req_write = 1'b0; req_user = 1'b1;
    #2;
    chk(rsp_valid == 1'b0, "R7 lookup during flush answered", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    #1;
    chk(walk_req_valid == 1'b1, "R7 flushed lookup walks", 64'(walk_req_valid), 64'd1);
    walk_done = 1'b1; walk_pte = mk_pte(40'h44444, 1'b1, 1'b1);
    @(negedge clk);
    walk_done = 1'b0;
    access(48'h7FFF_0000_0ABC, 1'b0, 1'b0, mk_pte(40'h11111, 1'b1, 1'b1), 1'b0, 0, h, c, pa);
    chk(h == 1'b0, "R7 entry gone after flush", 64'(h), 64'd0);

    // R8: empty cache, fill eight slots, then rotate
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int k = 0; k < 9; k++) begin
      access(pva(k), 1'b0, 1'b1, mk_pte(40'h300 + 40'(k), 1'b1, 1'b1), 1'b0, 0, h, c, pa);
      chk(h == 1'b0, $sformatf("R8 fill page %0d misses", k), 64'(h), 64'd0);
    end
    access(pva(1), 1'b0, 1'b1, '0, 1'b0, 0, h, c, pa);
    chk(h == 1'b1, "R8 slot 1 kept", 64'(h), 64'd1);
    access(pva(7), 1'b0, 1'b1, '0, 1'b0, 0, h, c, pa);
    chk(h == 1'b1, "R8 slot 7 kept", 64'(h), 64'd1);
    access(pva(0), 1'b0, 1'b1, mk_pte(40'h300, 1'b1, 1'b1), 1'b0, 0, h, c, pa);
    chk(h == 1'b0, "R8 slot 0 was first victim", 64'(h), 64'd0);
    access(pva(3), 1'b0, 1'b1, '0, 1'b0, 0, h, c, pa);
    chk(h == 1'b1, "R8 slot 3 kept", 64'(h), 64'd1);
    access(pva(1), 1'b0, 1'b1, mk_pte(40'h301, 1'b1, 1'b1), 1'b0, 0, h, c, pa);
    chk(h == 1'b0, "R8 pointer moved to slot 1", 64'(h), 64'd0);

    // R9: stall during a slow walk, other requests ignored
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 48'h0000_0000_9ABC; req_write = 1'b1; req_user = 1'b0;
    #2;
    chk(rsp_valid == 1'b0, "R9 miss no answer", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    req_vaddr = pva(3); req_write = 1'b0; req_user = 1'b1;
    #1;
    vpn_hold = walk_req_vpn;
    for (int j = 0; j < 3; j++) begin
      chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R9 busy ignores request",
          {62'd0, req_ready, rsp_valid}, 64'd0);
      @(negedge clk);
      #1;
    end
    chk(walk_req_vpn == vpn_hold && vpn_hold == 36'h9, "R3 vpn held", 64'(walk_req_vpn), 64'h9);
    req_valid = 1'b0;
    walk_done = 1'b1; walk_pte = mk_pte(40'h55555, 1'b0, 1'b0);
    #1;
    chk(rsp_fault == 2'd1, "R9 latched write kind used", 64'(rsp_fault), 64'd1);
    walk_pte = mk_pte(40'h55555, 1'b1, 1'b0);
    #1;
    chk(rsp_paddr == {40'h55555, 12'hABC}, "R9 latched offset used",
        64'(rsp_paddr), 64'({40'h55555, 12'hABC}));
    @(negedge clk);
    walk_done = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R9 ready after walk", 64'(req_ready), 64'd1);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule